// File: doc/BRIEF.md
# Dual-Clock Word FIFO

This block carries whole data words from one clock domain to a second, unrelated one without tearing a word apart. A producer in the write domain offers a word together with a valid bit and watches a full flag. A consumer in the read domain always sees the word at the head of the queue, plus an empty flag, and pulses a request to take that word away.

The queue is a small memory. It is written on the write clock and read without a clock. Each side keeps a binary pointer one bit wider than the address. The pointer is turned into Gray code in a register and sent to the other side through a chain of two flip-flops. Because the flags are built from pointers that arrive late, they are cautious. Empty can stay high for a short while after a write, and full can stay high for a short while after a read. A word is never lost and never delivered twice. Each domain has its own synchronous, active-high reset.

Top module: `xdom_word_fifo`

## Requirements
- R1: The parameter ADDR_W sets the queue capacity to exactly 2^ADDR_W words. Values of ADDR_W below 2 stop elaboration. Starting from empty, wr_full stays 0 through the first 2^ADDR_W-1 stored words.
- R2: A word is stored on a rising wr_clk edge only when wr_valid is 1 and wr_full is 0. Words offered while wr_full is 1 are dropped and never appear at rd_data.
- R3: The head advances on a rising rd_clk edge only when rd_req is 1 and rd_empty is 0. Requests made while rd_empty is 1 have no effect.
- R4: While rd_empty is 0, rd_data shows the oldest unread word, with no request and no read latency needed.
- R5: Words leave in the order they were written, with none lost and none duplicated, including when the pointers wrap around.
- R6: wr_full rises on the wr_clk edge that stores the word filling the last free slot. After a read frees a slot, wr_full is still 1 after two wr_clk edges and is 0 after the third wr_clk edge.
- R7: rd_empty rises on the rd_clk edge that takes the last word. After a write into an empty queue, rd_empty is still 1 after two rd_clk edges and is 0 after the third rd_clk edge.
- R8: Asserting wr_rst clears the write pointer and its synchronizer, so wr_full reads 0. Asserting rd_rst clears the read pointer and its synchronizer, so rd_empty reads 1. After both resets the queue is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Write-domain synchronous reset, active high |
| wr_valid | input | 1 | The offered word is valid |
| wr_data | input | DATA_W | Offered word |
| wr_full | output | 1 | Queue is full (write domain) |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Read-domain synchronous reset, active high |
| rd_req | input | 1 | Take the head word |
| rd_data | output | DATA_W | Oldest unread word |
| rd_empty | output | 1 | Queue is empty (read domain) |

## Verification
Results that stay in one domain are due at once. A flag raised by that side's own pointer moves on the same edge that moves the pointer, so the bench samples half a nanosecond after that edge. A flag cleared by the other side is due on the third edge of the observing clock: two synchronizer stages and then the flag register. The bench therefore counts observing-clock edges from the causing edge and checks both the second edge (flag still set) and the third (flag cleared). The two clock periods are chosen so that their rising edges never coincide, which makes these edge counts exact.

// File: rtl/xfifo_pkg.sv
`timescale 1ns/1ps
package xfifo_pkg;
  // flip-flops in each pointer crossing chain
  localparam int unsigned XING_STAGES = 2;
  // smallest address width that keeps the full-compare MSB split meaningful
  localparam int unsigned MIN_ADDR_W  = 2;
endpackage

// File: rtl/xfifo_xing.sv
`timescale 1ns/1ps
// Multi-flop crossing chain for a Gray-coded pointer
module xfifo_xing #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = xfifo_pkg::XING_STAGES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/xfifo_store.sv
`timescale 1ns/1ps
// Word storage: clocked write, combinational read-through
module xfifo_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/xfifo_wr_ctrl.sv
`timescale 1ns/1ps
// Write-side pointer and full flag
module xfifo_wr_ctrl #(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [ADDR_W:0]   rgray_sync,
  output logic              full,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W:0]   wgray
);
  localparam logic [ADDR_W:0] DEPTH_V = {1'b1, {ADDR_W{1'b0}}};

  logic [ADDR_W:0] wbin, wbin_nx, wgray_nx, full_cmp;
  logic            full_q;

  assign we       = valid & ~full_q;
  assign wbin_nx  = wbin + {{ADDR_W{1'b0}}, we};
  assign wgray_nx = (wbin_nx >> 1) ^ wbin_nx;
  assign full_cmp = {~rgray_sync[ADDR_W:ADDR_W-1], rgray_sync[ADDR_W-2:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin   <= '0;
      wgray  <= '0;
      full_q <= 1'b0;
    end else begin
      wbin   <= wbin_nx;
      wgray  <= wgray_nx;
      full_q <= (wgray_nx == full_cmp);
    end
  end

  assign full  = full_q;
  assign waddr = wbin[ADDR_W-1:0];

  // binary view of the synchronized read pointer, for the checks below
  logic [ADDR_W:0] rbin_seen;
  always_comb begin
    rbin_seen[ADDR_W] = rgray_sync[ADDR_W];
    for (int i = int'(ADDR_W) - 1; i >= 0; i--)
      rbin_seen[i] = rbin_seen[i+1] ^ rgray_sync[i];
  end

  // R1
  occupancy_chk: assert property (@(posedge clk) disable iff (rst)
    (wbin - rbin_seen) <= DEPTH_V);

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    full |=> $stable(wbin));

  // R2
  not_full_room_chk: assert property (@(posedge clk) disable iff (rst)
    !full |-> (wgray != full_cmp));
endmodule

// File: rtl/xfifo_rd_ctrl.sv
`timescale 1ns/1ps
// Read-side pointer and empty flag
module xfifo_rd_ctrl #(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [ADDR_W:0]   wgray_sync,
  output logic              empty,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W:0]   rgray
);
  logic [ADDR_W:0] rbin, rbin_nx, rgray_nx;
  logic            empty_q, re;

  assign re       = req & ~empty_q;
  assign rbin_nx  = rbin + {{ADDR_W{1'b0}}, re};
  assign rgray_nx = (rbin_nx >> 1) ^ rbin_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin    <= '0;
      rgray   <= '0;
      empty_q <= 1'b1;
    end else begin
      rbin    <= rbin_nx;
      rgray   <= rgray_nx;
      empty_q <= (rgray_nx == wgray_sync);
    end
  end

  assign empty = empty_q;
  assign raddr = rbin[ADDR_W-1:0];

  // R3
  empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    empty |=> $stable(rbin));

  // R5
  head_is_real_chk: assert property (@(posedge clk) disable iff (rst)
    !empty |-> (rgray != wgray_sync));
endmodule

// File: rtl/xdom_word_fifo.sv
`timescale 1ns/1ps
// Dual-clock FIFO for word-safe domain crossing
module xdom_word_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty
);
  localparam int unsigned PW = ADDR_W + 1;

  // R1: reject address widths that are too small
  if (ADDR_W < xfifo_pkg::MIN_ADDR_W) begin : g_bad_aw
    $error("xdom_word_fifo: ADDR_W must be at least 2");
  end

  logic [PW-1:0]     wgray, rgray, wgray_in_rd, rgray_in_wr;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              we;

  xfifo_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .clk(wr_clk), .rst(wr_rst), .valid(wr_valid), .rgray_sync(rgray_in_wr),
    .full(wr_full), .we(we), .waddr(waddr), .wgray(wgray)
  );

  xfifo_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .req(rd_req), .wgray_sync(wgray_in_rd),
    .empty(rd_empty), .raddr(raddr), .rgray(rgray)
  );

  xfifo_xing #(.W(PW)) u_w2r (
    .clk(rd_clk), .rst(rd_rst), .async_in(wgray), .sync_out(wgray_in_rd)
  );

  xfifo_xing #(.W(PW)) u_r2w (
    .clk(wr_clk), .rst(wr_rst), .async_in(rgray), .sync_out(rgray_in_wr)
  );

  xfifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(rd_data)
  );
endmodule

// File: tb/test_xdom_word_fifo.sv
`timescale 1ns/100ps
module test_xdom_word_fifo;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 3;
  localparam int unsigned DEPTH = 1 << AW;

  logic wr_clk = 0, rd_clk = 0;
  logic wr_rst = 1, rd_rst = 1;
  logic wr_valid = 0, rd_req = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic wr_full, rd_empty;

  int checks = 0, fails = 0;

  // 250 MHz write clock (rising at even ns), read clock rising at odd ns
  always #2 wr_clk = ~wr_clk;
  always #3 rd_clk = ~rd_clk;

  xdom_word_fifo #(.DATA_W(DW), .ADDR_W(AW)) i_xdom_word_fifo (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_full(wr_full), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_req(rd_req),
    .rd_data(rd_data), .rd_empty(rd_empty)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // take the head word; returns the value seen before the request
  task automatic pop(output logic [DW-1:0] head);
    @(negedge rd_clk);
    while (rd_empty) @(negedge rd_clk);
    head = rd_data;
    rd_req = 1;
    @(posedge rd_clk); #0.5;
    rd_req = 0;
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge wr_clk);
    while (wr_full) @(negedge wr_clk);
    wr_valid = 1; wr_data = d;
    @(posedge wr_clk); #0.5;
    wr_valid = 0;
  endtask

  task automatic do_reset();
    wr_valid = 0; rd_req = 0;
    wr_rst = 1; rd_rst = 1;
    repeat (4) @(posedge rd_clk);
    #0.5;
    wr_rst = 0; rd_rst = 0;
    repeat (2) @(negedge rd_clk);
    check(rd_empty === 1'b1, "R8 empty after reset", rd_empty, 1);
    check(wr_full === 1'b0, "R8 full after reset", wr_full, 0);
  endtask

  task automatic t_empty_latency();
    logic [DW-1:0] h;
    push(8'hA5);
    repeat (2) @(posedge rd_clk);
    #0.5 check(rd_empty === 1'b1, "R7 empty still set after two edges", rd_empty, 1);
    @(posedge rd_clk);
    #0.5 check(rd_empty === 1'b0, "R7 empty cleared on third edge", rd_empty, 0);
    check(rd_data === 8'hA5, "R4 head visible without request", rd_data, 8'hA5);
    pop(h);
    check(rd_empty === 1'b1, "R7 empty on consuming edge", rd_empty, 1);
  endtask

  task automatic t_fill();
    logic [DW-1:0] h;
    for (int i = 0; i < int'(DEPTH); i++) begin
      @(negedge wr_clk);
      wr_valid = 1; wr_data = 8'(8'h10 + i);
      @(posedge wr_clk);
      #0.5 check(wr_full === (i == int'(DEPTH) - 1), "R1 R6 full only at capacity",
                 wr_full, (i == int'(DEPTH) - 1));
    end
    for (int i = 0; i < 2; i++) begin
      @(negedge wr_clk); wr_valid = 1; wr_data = 8'hEE;
    end
    @(negedge wr_clk); wr_valid = 0;
    check(wr_full === 1'b1, "R2 full holds while offered", wr_full, 1);
    pop(h);
    check(h === 8'h10, "R5 first word", h, 8'h10);
    repeat (2) @(posedge wr_clk);
    #0.5 check(wr_full === 1'b1, "R6 full still set after two edges", wr_full, 1);
    @(posedge wr_clk);
    #0.5 check(wr_full === 1'b0, "R6 full cleared on third edge", wr_full, 0);
    for (int i = 1; i < int'(DEPTH); i++) begin
      pop(h);
      check(h === 8'(8'h10 + i), "R4 R5 drained in order", h, 8'h10 + i);
    end
    repeat (6) @(negedge rd_clk);
    check(rd_empty === 1'b1, "R2 dropped words never appear", rd_empty, 1);
  endtask

  task automatic t_empty_read();
    logic [DW-1:0] h;
    @(negedge rd_clk); rd_req = 1;
    repeat (5) @(negedge rd_clk);
    rd_req = 0;
    check(rd_empty === 1'b1, "R3 still empty after requests", rd_empty, 1);
    push(8'h5A);
    pop(h);
    check(h === 8'h5A, "R3 requests while empty ignored", h, 8'h5A);
    @(negedge rd_clk);
    check(rd_empty === 1'b1, "R3 one word taken once", rd_empty, 1);
  endtask

  task automatic t_stream();
    int sent = 0, got = 0, bad = 0;
    fork
      begin
        for (int cyc = 0; sent < 40; cyc++) begin
          @(negedge wr_clk);
          wr_valid = (cyc % 4 != 3) && !wr_full;
          wr_data  = 8'(sent * 7 + 3);
          @(posedge wr_clk);
          if (wr_valid) sent++;
        end
        @(negedge wr_clk); wr_valid = 0;
      end
      begin
        for (int cyc = 0; got < 40; cyc++) begin
          @(negedge rd_clk);
          if (!rd_empty && (cyc % 3 != 1)) begin
            if (rd_data !== 8'(got * 7 + 3)) begin
              bad++;
              check(0, "R5 stream order", rd_data, got * 7 + 3);
            end
            rd_req = 1; got++;
          end else rd_req = 0;
        end
        @(negedge rd_clk); rd_req = 0;
      end
    join
    check(bad == 0, "R5 stream with wrap intact", bad, 0);
    repeat (6) @(negedge rd_clk);
    check(rd_empty === 1'b1, "R5 no duplicate after stream", rd_empty, 1);
  endtask

  task automatic t_reset_midway();
    logic [DW-1:0] h;
    push(8'h01); push(8'h02); push(8'h03);
    repeat (6) @(negedge rd_clk);
    do_reset();
    push(8'h77);
    pop(h);
    check(h === 8'h77, "R8 restart after reset", h, 8'h77);
  endtask

  initial begin
    repeat (200000) @(posedge wr_clk);
    check(0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    do_reset();
    t_empty_latency();
    t_fill();
    t_empty_read();
    t_stream();
    t_reset_midway();
    summary();
    $finish;
  end
endmodule